// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller with Supply-Fail Write Lockout

This block sits between a synchronous host and an 8K x 8 asynchronous static RAM. The host issues one request at a time: a read or a write, an address and write data, through a valid/ready handshake. The controller turns each accepted request into a timed sequence on the memory's active-low chip-enable, write-enable and output-enable strobes. It also controls the enable of the shared data bus and returns the read data, or an error flag, as a one-cycle response.

The timing is set in clock cycles through three runtime inputs: the access time for reads, the write pulse width and the recovery gap after a write. A zero in any of them is treated as one. The write window is the overlap of chip-enable and write-enable. The address is frozen from acceptance until chip-enable returns high.

A power-fail input stands in for a supply comparator and only affects writes. A write requested while it is high ends at once with an error and produces no strobe activity. If it rises during a write, write-enable is released on the next edge and the response carries the error. Reads are not affected by it.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, req_ready is 1 and rsp_valid is 0.
- R2: An accepted read (req_write=0) holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for exactly max(cfg_acc,1) cycles starting the cycle after acceptance. The next cycle gives rsp_valid=1, rsp_err=0, and rsp_rdata equal to mem_dq_in as it stood in the last access cycle.
- R3: An accepted write (req_write=1, pwr_fail=0) first gives one setup cycle with mem_ce_n=0, mem_we_n=1 and mem_dq_oe=1, with req_wdata on mem_dq_out. This is followed by max(cfg_wp,1) cycles with mem_ce_n=0 and mem_we_n=0.
- R4: After the write pulse, all strobes are 1 and mem_dq_oe is 0 for max(cfg_rec,1) cycles while req_ready stays 0. The following cycle gives rsp_valid=1 with rsp_err=0 and req_ready=1.
- R5: mem_addr equals the accepted req_addr and does not change while mem_ce_n is 0.
- R6: mem_dq_oe is 1 only in the write setup and pulse cycles. mem_oe_n is 1 whenever mem_dq_oe or mem_we_n is 0.
- R7: A write accepted while pwr_fail=1 causes no strobe activity and leaves the memory unchanged. It gives rsp_valid=1 with rsp_err=1 in the very next cycle, and req_ready stays 1.
- R8: If pwr_fail is 1 at a clock edge during the write pulse, mem_we_n and mem_dq_oe become 1 and 0 at that edge. The full recovery still follows, and the response carries rsp_err=1.
- R9: A cfg_acc, cfg_wp or cfg_rec value of 0 behaves as 1.
- R10: req_ready is 0 from the edge that accepts a request until the cycle in which its response is valid. No response appears without a request.
- R11: Reads run normally with rsp_err=0 while pwr_fail is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with rsp_valid on reads |
| rsp_err | output | 1 | Write blocked or cut by power fail |
| pwr_fail | input | 1 | Supply-fail indication, high = fail |
| cfg_acc | input | 4 | Read access cycles (0 acts as 1) |
| cfg_wp | input | 4 | Write pulse cycles (0 acts as 1) |
| cfg_rec | input | 4 | Write recovery cycles (0 acts as 1) |
| mem_addr | output | 13 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Data driven toward memory |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | 8 | Data returned from memory |

## Verification
A sequencer stuck in or skipping a state would show as a strobe window one cycle too long or too short. It would appear within the first request, because the bench checks every cycle of every strobe window against the programmed counts. A lost error bit or a wrong capture moment shows in the response right after completion: a wrong read byte, a missing error on a blocked or cut write, or a response with no request behind it. A write-enable that survives a power-fail edge, or a bus driver left on, shows one cycle after the edge that should have cut it.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and helpers for the SRAM strobe controller.
// Assumes: state encoding is internal; only the enum names are relied on.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_WSETUP = 3'd2,
        ST_WPULSE = 3'd3,
        ST_WRECOV = 3'd4
    } seq_state_e;

    // Replace a zero cycle count by one so every phase lasts at least a cycle.
    function automatic logic [15:0] at_least_one(input logic [15:0] v);
        return (v == 16'd0) ? 16'd1 : v;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
// Down-counter that times one strobe phase.
// Loads a cycle count (zero is taken as one) and flags the last cycle.
// Assumes: the loader re-loads on every phase entry; counting stops at 1.
module sram_cycle_timer
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    // Load a fresh phase length, otherwise count down toward one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ONE;
        end else if (load) begin
            cnt_q <= (load_val == '0) ? ONE : load_val;
        end else if (cnt_q > ONE) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign last = (cnt_q <= ONE);

endmodule

// File: rtl/sram_seq_fsm.sv
// Strobe sequencer: accepts one request at a time, steps through read,
// write setup, write pulse and write recovery, and drives registered
// strobes so they change only at clock edges.
// Assumes: the timer is loaded on each phase entry and reports its last cycle.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             pwr_fail,
    input  logic [CNT_W-1:0] cfg_acc,
    input  logic [CNT_W-1:0] cfg_wp,
    input  logic [CNT_W-1:0] cfg_rec,
    input  logic             tmr_last,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             req_ready,
    output logic             accept,
    output logic             capture,
    output logic             rsp_valid,
    output logic             rsp_err,
    output logic             ce_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             dq_oe
);

    seq_state_e state_q, state_d;
    logic       err_q, err_d;
    logic       finish, finish_err;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign capture   = (state_q == ST_READ) && tmr_last;

    // Next-state, timer load and completion decode.
    always_comb begin
        state_d    = state_q;
        err_d      = err_q;
        tmr_load   = 1'b0;
        tmr_val    = cfg_acc;
        finish     = 1'b0;
        finish_err = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    err_d = 1'b0;
                    if (!req_write) begin
                        state_d  = ST_READ;
                        tmr_load = 1'b1;
                        tmr_val  = cfg_acc;
                    end else if (pwr_fail) begin
                        finish     = 1'b1;
                        finish_err = 1'b1;
                    end else begin
                        state_d = ST_WSETUP;
                    end
                end
            end
            ST_READ: begin
                if (tmr_last) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            ST_WSETUP: begin
                tmr_load = 1'b1;
                if (pwr_fail) begin
                    state_d = ST_WRECOV;
                    err_d   = 1'b1;
                    tmr_val = cfg_rec;
                end else begin
                    state_d = ST_WPULSE;
                    tmr_val = cfg_wp;
                end
            end
            ST_WPULSE: begin
                if (pwr_fail || tmr_last) begin
                    state_d  = ST_WRECOV;
                    tmr_load = 1'b1;
                    tmr_val  = cfg_rec;
                    if (pwr_fail) err_d = 1'b1;
                end
            end
            ST_WRECOV: begin
                if (tmr_last) begin
                    state_d    = ST_IDLE;
                    finish     = 1'b1;
                    finish_err = err_q;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, error flag and response pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            err_q     <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
        end else begin
            state_q   <= state_d;
            err_q     <= err_d;
            rsp_valid <= finish;
            rsp_err   <= finish && finish_err;
        end
    end

    // Strobes registered from the next state so they never glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n  <= 1'b1;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            ce_n  <= !(state_d == ST_READ || state_d == ST_WSETUP || state_d == ST_WPULSE);
            we_n  <= !(state_d == ST_WPULSE);
            oe_n  <= !(state_d == ST_READ);
            dq_oe <= (state_d == ST_WSETUP || state_d == ST_WPULSE);
        end
    end

    // R6
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    // R6
    drive_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);

    // R6
    we_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> dq_oe);

    // R3
    we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !ce_n);

    // R8
    pf_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_fail && !we_n) |=> we_n);

    // R7
    pf_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_fail && we_n) |=> we_n);

    // R10
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |-> !req_ready);

endmodule

// File: rtl/sram_bus_path.sv
// Address, write-data and read-data registers for the memory bus.
// Latches the request on acceptance and holds it until the next one;
// captures memory data on the last access cycle of a read.
// Assumes: accept is only raised while the sequencer is idle.
module sram_bus_path #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] mem_dq_in,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic [DW-1:0] rsp_rdata
);

    // Freeze address and write data for the whole accepted cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Sample returned memory data at the end of the access window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if (capture) begin
            rsp_rdata <= mem_dq_in;
        end
    end

endmodule

// File: rtl/sram_strobe_ctrl.sv
// Top level: host request port to asynchronous SRAM strobes, with a
// supply-fail write lockout. Ties the sequencer, phase timer and bus path.
// Assumes: one outstanding request; cfg_* stable while a request runs.
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW    = 13,
    parameter int DW    = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata,
    output logic             rsp_err,
    input  logic             pwr_fail,
    input  logic [CNT_W-1:0] cfg_acc,
    input  logic [CNT_W-1:0] cfg_wp,
    input  logic [CNT_W-1:0] cfg_rec,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_ce_n,
    output logic             mem_we_n,
    output logic             mem_oe_n,
    output logic [DW-1:0]    mem_dq_out,
    output logic             mem_dq_oe,
    input  logic [DW-1:0]    mem_dq_in
);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_last;
    logic             accept;
    logic             capture;

    sram_seq_fsm #(.CNT_W(CNT_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .pwr_fail  (pwr_fail),
        .cfg_acc   (cfg_acc),
        .cfg_wp    (cfg_wp),
        .cfg_rec   (cfg_rec),
        .tmr_last  (tmr_last),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .ce_n      (mem_ce_n),
        .we_n      (mem_we_n),
        .oe_n      (mem_oe_n),
        .dq_oe     (mem_dq_oe)
    );

    sram_cycle_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_bus_path #(.AW(AW), .DW(DW)) path_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .capture    (capture),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rsp_rdata  (rsp_rdata)
    );

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    // R7
    pf_rsp_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_write && pwr_fail) |=> (rsp_valid && rsp_err));

endmodule

// File: tb/sram_strobe_ctrl_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected responses, a monitor pops
// and compares them; strobe windows are checked cycle by cycle.
module sram_strobe_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, pwr_fail;
    logic [12:0] req_addr;
    logic [7:0]  req_wdata;
    logic [3:0]  cfg_acc, cfg_wp, cfg_rec;
    logic        req_ready, rsp_valid, rsp_err;
    logic [7:0]  rsp_rdata;
    logic [12:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'h00;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    logic [9:0] exp_q[$];          // {is_read, err, data}
    logic [7:0] mem_store[logic [12:0]];
    logic [7:0] ref_mem[logic [12:0]];

    always #2.5 clk = ~clk;

    sram_strobe_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .pwr_fail(pwr_fail), .cfg_acc(cfg_acc), .cfg_wp(cfg_wp), .cfg_rec(cfg_rec),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    function automatic logic [7:0] pat(input logic [12:0] a);
        return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A;
    endfunction

    function automatic int eff(input logic [3:0] v);
        return (v == 4'd0) ? 1 : int'(v);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Memory model: stores during the write overlap, returns data when read-enabled.
    always @(negedge clk) begin
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) mem_store[mem_addr] = mem_dq_out;
        if (!mem_ce_n && !mem_oe_n)
            mem_dq_in <= mem_store.exists(mem_addr) ? mem_store[mem_addr] : pat(mem_addr);
        else
            mem_dq_in <= 8'h00;
    end

    // Monitor: pop the expected response and compare.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R10 unexpected response", 1, 0);
            end else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                chk(rsp_err == e[8], "R7/R8/R11 rsp_err", rsp_err, e[8]);
                if (e[9]) chk(rsp_rdata == e[7:0], "R2 rsp_rdata", rsp_rdata, e[7:0]);
            end
        end
    end

    task automatic issue(input logic wr, input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);  // first cycle after acceptance
        req_valid = 1'b0;
    endtask

    task automatic do_read(input logic [12:0] a);
        logic [7:0] e;
        int n;
        e = ref_mem.exists(a) ? ref_mem[a] : pat(a);
        exp_q.push_back({1'b1, 1'b0, e});
        n = eff(cfg_acc);
        issue(1'b0, a, 8'h00);
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            chk(!mem_ce_n && !mem_oe_n && mem_we_n, "R2 read strobes", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b001);
            chk(mem_addr == a, "R5 address held", mem_addr, a);
            chk(!req_ready, "R10 busy", req_ready, 0);
        end
        @(negedge clk);
        chk(rsp_valid && mem_ce_n && mem_oe_n && req_ready, "R2 read end", {rsp_valid, mem_ce_n, mem_oe_n, req_ready}, 4'hF);
    endtask

    task automatic do_write(input logic [12:0] a, input logic [7:0] d);
        int p, r;
        exp_q.push_back({1'b0, 1'b0, 8'h00});
        ref_mem[a] = d;
        p = eff(cfg_wp);
        r = eff(cfg_rec);
        issue(1'b1, a, d);
        chk(!mem_ce_n && mem_we_n && mem_dq_oe && mem_oe_n, "R3 setup cycle", {mem_ce_n, mem_we_n, mem_dq_oe, mem_oe_n}, 4'b0111);
        chk(mem_dq_out == d, "R3 write data", mem_dq_out, d);
        for (int i = 0; i < p; i++) begin
            @(negedge clk);
            chk(!mem_ce_n && !mem_we_n && mem_dq_oe && mem_oe_n, "R3/R6 pulse", {mem_ce_n, mem_we_n, mem_dq_oe, mem_oe_n}, 4'b0011);
            chk(mem_addr == a, "R5 address held", mem_addr, a);
        end
        for (int i = 0; i < r; i++) begin
            @(negedge clk);
            chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !req_ready && !rsp_valid, "R4 recovery",
                {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid}, 6'b111000);
        end
        @(negedge clk);
        chk(rsp_valid && req_ready, "R4 write done", {rsp_valid, req_ready}, 2'b11);
    endtask

    task automatic blocked_write(input logic [12:0] a, input logic [7:0] d);
        exp_q.push_back({1'b0, 1'b1, 8'h00});
        pwr_fail = 1'b1;
        issue(1'b1, a, d);
        chk(mem_ce_n && mem_we_n && !mem_dq_oe && req_ready && rsp_valid, "R7 blocked write",
            {mem_ce_n, mem_we_n, mem_dq_oe, req_ready, rsp_valid}, 5'b11011);
        pwr_fail = 1'b0;
        @(negedge clk);
    endtask

    // Power fail rises in the second pulse cycle; cfg_wp must exceed 2.
    task automatic cut_write(input logic [12:0] a, input logic [7:0] d);
        int r;
        exp_q.push_back({1'b0, 1'b1, 8'h00});
        r = eff(cfg_rec);
        issue(1'b1, a, d);
        @(negedge clk);
        @(negedge clk);
        chk(!mem_we_n, "R8 pulse before fail", mem_we_n, 0);
        pwr_fail = 1'b1;
        for (int i = 0; i < r; i++) begin
            @(negedge clk);
            chk(mem_we_n && mem_ce_n && !mem_dq_oe && !req_ready, "R8 cut and recover",
                {mem_we_n, mem_ce_n, mem_dq_oe, req_ready}, 4'b1100);
        end
        @(negedge clk);
        chk(rsp_valid, "R8 response", rsp_valid, 1);
        pwr_fail = 1'b0;
        ref_mem.delete(a);
        mem_store.delete(a);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_wdata = '0; pwr_fail = 1'b0; cfg_acc = 4'd3; cfg_wp = 4'd2; cfg_rec = 4'd2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rsp_valid, "R1 reset state",
            {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid}, 6'b111010);

        do_write(13'h0123, 8'hA5);
        do_read(13'h0123);
        do_read(13'h1FFF);

        cfg_acc = 4'd0; cfg_wp = 4'd0; cfg_rec = 4'd0;   // R9
        do_write(13'h0000, 8'h3C);
        do_read(13'h0000);

        cfg_acc = 4'd6; cfg_wp = 4'd4; cfg_rec = 4'd3;
        do_write(13'h0040, 8'h11);
        blocked_write(13'h0040, 8'h22);                  // R7
        do_read(13'h0040);

        cfg_wp = 4'd5; cfg_rec = 4'd2;
        cut_write(13'h0800, 8'h77);                      // R8

        pwr_fail = 1'b1;                                 // R11
        do_read(13'h0123);
        pwr_fail = 1'b0;

        cfg_acc = 4'd15; cfg_wp = 4'd15; cfg_rec = 4'd1;
        do_write(13'h1FFF, 8'hFF);
        do_read(13'h1FFF);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R10 all responses seen", exp_q.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule